// File: doc/BRIEF.md
# Pulse Position and Polarity Mapper

This block turns a stream of coded bits into a schedule of impulse-radio pulses. Time is cut into slots. Each slot lasts one pulse repetition period, counted in cycles of the fast clock. Every slot carries one symbol, made of a sign (+1 or -1) and one of Np positions inside the slot. Position p is emitted p times the programmed spacing after the start of the slot. The block produces two strobes. A per-slot strobe carries the chosen position index and the sign. A second strobe marks the exact cycle at which the external pulse generator must fire.

A frame starts with a request/acknowledge exchange and then has two phases. First comes a training preamble. In each preamble slot, the hop offset and the sign are read from a small training table that is loaded through a write port. Then comes the data body. Its symbols are built from incoming serial bits, 1+log2(Np) bits per pulse. In the body, the training table can optionally add a time-hopping offset to the data position. The slot period, the spacing and Np are all set at run time, so the symbol rate scales without changing the fast clock. When no complete data symbol is waiting at a slot boundary, the slot timer stalls and no pulse is emitted.

Top module: `ppm_pulse_mapper`

## Requirements
- R1: When `start_req` is high in a cycle where the block is idle, `start_ack` pulses for one cycle on the next cycle and the configuration is latched. A `start_req` raised while a frame is running produces no acknowledge and does not change the slots.
- R2: Preamble slot i (i from 0 to `cfg_pre_len`-1) uses table entry i. Entry bit 3 is the sign (1 means negative) and bits 2:0 are the hop offset. The slot position is hop mod Np, and `slot_preamble` is 1.
- R3: Data bits are taken in groups of 1+`cfg_np_log2` bits. The first bit of a group is the sign (1 means negative). The remaining bits give the position, most significant bit first. `slot_preamble` is 0 for data slots.
- R4: The first `slot_stb` comes one cycle after `start_ack`. Later slots follow exactly `cfg_prp` cycles apart, as long as each data group is complete when its slot begins.
- R5: Every slot produces exactly one `fire_stb`, `slot_pos`×`cfg_spacing` cycles after its `slot_stb`. For position 0, the two strobes occur in the same cycle.
- R6: If a data group is incomplete at a slot boundary, the timer holds and no strobe is issued. The slot then appears one cycle after the clock edge that accepts the last bit of the group.
- R7: With `cfg_data_hop`=1, the position of data symbol k is (data position + hop offset of table entry k mod 16) mod Np. The sign still comes from the data.
- R8: `frame_done` pulses for one cycle `cfg_prp`-1 cycles after the last `slot_stb` of the frame. After that the block is idle.
- R9: `bit_ready` is low while the block is idle and while a complete group waits for its slot.
- R10: `cfg_np_log2` takes the values 1 to 3 (Np = 2, 4, 8), and `slot_pos` is always below Np.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prp | input | 16 | Slot period in clock cycles (at least 2) |
| cfg_spacing | input | 16 | Cycles between adjacent positions |
| cfg_np_log2 | input | 2 | log2 of Np, from 1 to 3 |
| cfg_pre_len | input | 5 | Number of preamble slots, from 0 to 16 |
| cfg_body_len | input | 12 | Number of data symbols |
| cfg_data_hop | input | 1 | Add the table hop offset to data positions |
| start_req | input | 1 | Frame start request |
| start_ack | output | 1 | Frame start accepted (one-cycle pulse) |
| tbl_we | input | 1 | Training table write enable |
| tbl_addr | input | 4 | Training table write address |
| tbl_wdata | input | 4 | Table entry: sign in bit 3, hop offset in bits 2:0 |
| bit_valid | input | 1 | Serial data bit valid |
| bit_data | input | 1 | Serial data bit |
| bit_ready | output | 1 | Block accepts a bit on this cycle |
| slot_stb | output | 1 | Start-of-slot strobe |
| slot_pos | output | 3 | Position index of the slot |
| slot_neg | output | 1 | Sign of the slot, 1 meaning negative |
| slot_preamble | output | 1 | Slot belongs to the preamble |
| fire_stb | output | 1 | Pulse emission instant |
| frame_done | output | 1 | Frame finished (one-cycle pulse) |

## Verification
The assertions assume a legal configuration:
- `cfg_prp` is at least 2.
- `cfg_spacing`×(Np-1) is below `cfg_prp`.
- `cfg_pre_len` does not exceed the table depth.
- `cfg_np_log2` lies in 1 to 3.
- The table is not written during a frame or in the cycle just before a start.

The stimulus loads the whole table while the block is idle. Every configuration it selects satisfies these bounds, including the tightest case where the last position lands on the final cycle of the slot. Data is delivered both early and with gaps long enough to stall the timer, so both the fixed-period and the held-slot timing are exercised.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } ppm_state_e;
endpackage

// File: rtl/ppm_bit_packer.sv
module ppm_bit_packer #(
  parameter int PW = 3,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr,
  input  logic [LW-1:0] np_log2,
  input  logic          bit_valid,
  input  logic          bit_data,
  input  logic          take,
  output logic          ready,
  output logic          full,
  output logic          sym_neg,
  output logic [PW-1:0] sym_pos
);
  localparam int SW = PW + 1;
  localparam int FW = $clog2(SW + 1);

  logic [SW-1:0] sh_q;
  logic [FW-1:0] fill_q;
  logic [FW-1:0] group;
  logic [PW-1:0] mask;

  assign group   = FW'(np_log2) + FW'(1);
  assign full    = (fill_q == group);
  assign ready   = en && !full;
  assign mask    = ~({PW{1'b1}} << np_log2);
  assign sym_pos = sh_q[PW-1:0] & mask;
  assign sym_neg = sh_q[np_log2];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (take) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (bit_valid && ready) begin
      sh_q   <= {sh_q[SW-2:0], bit_data};
      fill_q <= fill_q + FW'(1);
    end
  end

  // R6: a symbol is only consumed once its group is complete
  a_r6_take_only_full: assert property (@(posedge clk) disable iff (rst)
    take |-> full);
  // R3: the group never grows past 1+log2(Np) bits
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && ready) |=> (fill_q <= group) || $past(clr));
endmodule

// File: rtl/ppm_train_ram.sv
module ppm_train_ram #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ppm_slot_timer.sv
module ppm_slot_timer #(
  parameter int CW = 16,
  parameter int TW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          hold,
  input  logic [CW-1:0] prp,
  input  logic          arm,
  input  logic [TW-1:0] target,
  output logic          at_zero,
  output logic          at_last,
  output logic          fire
);
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tgt_q;
  logic          live_q;
  logic          fire_q;
  logic          hit;

  assign at_zero = (cnt_q == '0);
  assign at_last = (cnt_q == prp - CW'(1));
  assign hit     = live_q && (TW'(cnt_q) == tgt_q);
  assign fire    = fire_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      tgt_q  <= '0;
      live_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      if (!hold) cnt_q <= at_last ? '0 : cnt_q + CW'(1);
      fire_q <= (arm && (target == '0)) || hit;
      if (arm) begin
        tgt_q  <= target;
        live_q <= (target != '0);
      end else if (hit) begin
        live_q <= 1'b0;
      end
    end
  end

  // R4: slots are issued only on a period boundary
  a_r4_arm_on_boundary: assert property (@(posedge clk) disable iff (rst)
    arm |-> (cnt_q == '0));
  // R5: the previous slot has fired before the next one is armed
  a_r5_fire_before_rearm: assert property (@(posedge clk) disable iff (rst)
    arm |-> !live_q);
endmodule

// File: rtl/ppm_pulse_mapper.sv
module ppm_pulse_mapper #(
  parameter int NP_MAX    = 8,
  parameter int CNT_W     = 16,
  parameter int TBL_DEPTH = 16,
  parameter int LEN_W     = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CNT_W-1:0]             cfg_prp,
  input  logic [CNT_W-1:0]             cfg_spacing,
  input  logic [$clog2($clog2(NP_MAX)+1)-1:0] cfg_np_log2,
  input  logic [$clog2(TBL_DEPTH):0]   cfg_pre_len,
  input  logic [LEN_W-1:0]             cfg_body_len,
  input  logic                         cfg_data_hop,
  input  logic                         start_req,
  output logic                         start_ack,
  input  logic                         tbl_we,
  input  logic [$clog2(TBL_DEPTH)-1:0] tbl_addr,
  input  logic [$clog2(NP_MAX):0]      tbl_wdata,
  input  logic                         bit_valid,
  input  logic                         bit_data,
  output logic                         bit_ready,
  output logic                         slot_stb,
  output logic [$clog2(NP_MAX)-1:0]    slot_pos,
  output logic                         slot_neg,
  output logic                         slot_preamble,
  output logic                         fire_stb,
  output logic                         frame_done
);
  import ppm_pkg::*;

  localparam int PW = $clog2(NP_MAX);
  localparam int LW = $clog2(PW + 1);
  localparam int AW = $clog2(TBL_DEPTH);
  localparam int TW = CNT_W + PW;

  ppm_state_e     state_q;
  logic [CNT_W-1:0] prp_q, sp_q;
  logic [LW-1:0]  nl_q;
  logic [AW:0]    pre_q, pre_idx_q;
  logic [LEN_W-1:0] body_q, dat_idx_q;
  logic           hop_q;
  logic [AW-1:0]  rd_addr_q;
  logic [PW:0]    tbl_q;

  logic           at_zero, at_last, tm_fire;
  logic           pk_full, pk_neg;
  logic [PW-1:0]  pk_pos;
  logic           pre_emit, dat_emit, arm, hold, run, accept;
  logic [PW-1:0]  mask, tbl_hop, sel_pos;
  logic           sel_neg;
  logic [TW-1:0]  target;

  assign run      = (state_q != ST_IDLE);
  assign accept   = (state_q == ST_IDLE) && start_req;
  assign pre_emit = (state_q == ST_PRE) && at_zero;
  assign dat_emit = (state_q == ST_DATA) && at_zero && pk_full;
  assign hold     = (state_q == ST_DATA) && at_zero && !pk_full;
  assign arm      = pre_emit || dat_emit;
  assign mask     = ~({PW{1'b1}} << nl_q);
  assign tbl_hop  = tbl_q[PW-1:0];

  always_comb begin
    if (pre_emit) begin
      sel_pos = tbl_hop & mask;
      sel_neg = tbl_q[PW];
    end else begin
      sel_pos = cfg_hop_sum(hop_q, pk_pos, tbl_hop, mask);
      sel_neg = pk_neg;
    end
  end

  function automatic logic [PW-1:0] cfg_hop_sum(input logic en, input logic [PW-1:0] p,
                                                input logic [PW-1:0] h, input logic [PW-1:0] m);
    return en ? ((p + h) & m) : p;
  endfunction

  assign target = TW'(sel_pos) * TW'(sp_q);

  ppm_train_ram #(.AW(AW), .DW(PW + 1)) ram_i (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (rd_addr_q),
    .rdata (tbl_q)
  );

  ppm_bit_packer #(.PW(PW), .LW(LW)) packer_i (
    .clk       (clk),
    .rst       (rst),
    .en        ((state_q == ST_PRE) || (state_q == ST_DATA)),
    .clr       (accept),
    .np_log2   (nl_q),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .take      (dat_emit),
    .ready     (bit_ready),
    .full      (pk_full),
    .sym_neg   (pk_neg),
    .sym_pos   (pk_pos)
  );

  ppm_slot_timer #(.CW(CNT_W), .TW(TW)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .hold    (hold),
    .prp     (prp_q),
    .arm     (arm),
    .target  (target),
    .at_zero (at_zero),
    .at_last (at_last),
    .fire    (tm_fire)
  );

  assign fire_stb = tm_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      prp_q         <= CNT_W'(2);
      sp_q          <= '0;
      nl_q          <= LW'(1);
      pre_q         <= '0;
      body_q        <= '0;
      hop_q         <= 1'b0;
      pre_idx_q     <= '0;
      dat_idx_q     <= '0;
      rd_addr_q     <= '0;
      start_ack     <= 1'b0;
      slot_stb      <= 1'b0;
      slot_pos      <= '0;
      slot_neg      <= 1'b0;
      slot_preamble <= 1'b0;
      frame_done    <= 1'b0;
    end else begin
      start_ack  <= 1'b0;
      slot_stb   <= 1'b0;
      frame_done <= 1'b0;
      if (arm) begin
        slot_stb      <= 1'b1;
        slot_pos      <= sel_pos;
        slot_neg      <= sel_neg;
        slot_preamble <= pre_emit;
      end
      unique case (state_q)
        ST_IDLE: begin
          rd_addr_q <= '0;
          if (start_req) begin
            start_ack <= 1'b1;
            prp_q     <= cfg_prp;
            sp_q      <= cfg_spacing;
            nl_q      <= cfg_np_log2;
            pre_q     <= cfg_pre_len;
            body_q    <= cfg_body_len;
            hop_q     <= cfg_data_hop;
            pre_idx_q <= '0;
            dat_idx_q <= '0;
            if (cfg_pre_len != '0)       state_q <= ST_PRE;
            else if (cfg_body_len != '0) state_q <= ST_DATA;
            else                         state_q <= ST_FIN;
          end
        end
        ST_PRE: begin
          if (at_zero) begin
            pre_idx_q <= pre_idx_q + (AW+1)'(1);
            if (pre_idx_q == pre_q - (AW+1)'(1)) begin
              rd_addr_q <= '0;
              state_q   <= (body_q != '0) ? ST_DATA : ST_FIN;
            end else begin
              rd_addr_q <= pre_idx_q[AW-1:0] + AW'(1);
            end
          end
        end
        ST_DATA: begin
          if (dat_emit) begin
            dat_idx_q <= dat_idx_q + LEN_W'(1);
            rd_addr_q <= AW'(dat_idx_q + LEN_W'(1));
            if (dat_idx_q == body_q - LEN_W'(1)) state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          rd_addr_q <= '0;
          if (at_last) begin
            state_q    <= ST_IDLE;
            frame_done <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: an acknowledge only ever answers a request seen while idle
  a_r1_ack_from_idle: assert property (@(posedge clk) disable iff (rst)
    start_ack |-> $past(state_q == ST_IDLE && start_req));
  // R10: every emitted position lies below Np
  a_r10_pos_below_np: assert property (@(posedge clk) disable iff (rst)
    slot_stb |-> ((slot_pos >> nl_q) == '0));
  // R9: no bit is accepted while idle
  a_r9_ready_low_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !bit_ready);
  // R8: completion only follows the closing slot
  a_r8_done_after_fin: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(state_q == ST_FIN));
endmodule

// File: tb/ppm_pulse_mapper_tb.sv
module ppm_pulse_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_prp = 16'd4, cfg_spacing = 16'd1;
  logic [1:0]  cfg_np_log2 = 2'd1;
  logic [4:0]  cfg_pre_len = 5'd0;
  logic [11:0] cfg_body_len = 12'd0;
  logic        cfg_data_hop = 1'b0;
  logic        start_req = 1'b0, start_ack;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_addr = 4'd0, tbl_wdata = 4'd0;
  logic        bit_valid = 1'b0, bit_data = 1'b0, bit_ready;
  logic        slot_stb, slot_neg, slot_preamble, fire_stb, frame_done;
  logic [2:0]  slot_pos;

  always #2 clk = ~clk;

  ppm_pulse_mapper dut_i (
    .clk(clk), .rst(rst), .cfg_prp(cfg_prp), .cfg_spacing(cfg_spacing),
    .cfg_np_log2(cfg_np_log2), .cfg_pre_len(cfg_pre_len), .cfg_body_len(cfg_body_len),
    .cfg_data_hop(cfg_data_hop), .start_req(start_req), .start_ack(start_ack),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .slot_stb(slot_stb), .slot_pos(slot_pos), .slot_neg(slot_neg),
    .slot_preamble(slot_preamble), .fire_stb(fire_stb), .frame_done(frame_done)
  );

  int total = 0, bad = 0, cyc = 0;
  int ev_cyc[64], ev_pos[64], ev_neg[64], ev_pre[64], fire_cyc[64], acc[64];
  int n_ev = 0, n_fire = 0, done_cyc = -1, ack_cnt = 0, ack_cyc = 0;

  function automatic int t_hop(int i); return (i * 5 + 3) % 8; endfunction
  function automatic int t_neg(int i); return ((i * 7) >> 2) & 1; endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (!rst) begin
    if (slot_stb && n_ev < 64) begin
      ev_cyc[n_ev] = cyc; ev_pos[n_ev] = int'(slot_pos);
      ev_neg[n_ev] = int'(slot_neg); ev_pre[n_ev] = int'(slot_preamble);
      n_ev++;
    end
    if (fire_stb && n_fire < 64) begin fire_cyc[n_fire] = cyc; n_fire++; end
    if (frame_done) done_cyc = cyc;
    if (start_ack) begin ack_cnt++; ack_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input int b);
    bit_valid = 1'b1; bit_data = b[0];
    while (!bit_ready) @(negedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic run_frame(input int nl, input int prp, input int sp, input int pre,
                           input int body, input int hop, input int gap, input int mode);
    int g, msk, prev, expc, v, dp, ep, en_, k;
    g = nl + 1; msk = (1 << nl) - 1;
    @(negedge clk);
    chk(bit_ready == 1'b0, "R9 ready low idle", int'(bit_ready), 0);
    n_ev = 0; n_fire = 0; done_cyc = -1; ack_cnt = 0;
    cfg_np_log2 = 2'(nl); cfg_prp = 16'(prp); cfg_spacing = 16'(sp);
    cfg_pre_len = 5'(pre); cfg_body_len = 12'(body); cfg_data_hop = hop[0];
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    for (int s = 0; s < body; s++) begin
      v = (mode == 0) ? (s % (1 << g)) : ((s * 3 + 1) % (1 << g));
      if (gap > 0 && (s % 3) == 1) repeat (gap) @(negedge clk);
      for (int b = g - 1; b >= 0; b--) send_bit((v >> b) & 1);
      acc[s] = cyc;
      if (s == 0) begin
        start_req = 1'b1; @(negedge clk); start_req = 1'b0;
      end
    end
    while (done_cyc < 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ack_cnt == 1, "R1 single ack per frame", ack_cnt, 1);
    chk(n_ev == pre + body, "R1 slot count", n_ev, pre + body);
    chk(n_fire == n_ev, "R5 one fire per slot", n_fire, n_ev);
    prev = ack_cyc + 1 - prp;
    for (int i = 0; i < n_ev && i < pre + body; i++) begin
      if (i < pre) begin
        expc = prev + prp;
        ep = t_hop(i) & msk; en_ = t_neg(i);
        chk(ev_pre[i] == 1, "R2 preamble flag", ev_pre[i], 1);
        chk(ev_pos[i] == ep, "R2 preamble position", ev_pos[i], ep);
        chk(ev_neg[i] == en_, "R2 preamble sign", ev_neg[i], en_);
        chk(ev_cyc[i] == expc, "R4 preamble slot timing", ev_cyc[i], expc);
      end else begin
        k = i - pre;
        v = (mode == 0) ? (k % (1 << g)) : ((k * 3 + 1) % (1 << g));
        dp = v & msk; en_ = (v >> nl) & 1;
        ep = (hop != 0) ? ((dp + t_hop(k % 16)) & msk) : dp;
        expc = (acc[k] + 1 > prev + prp) ? acc[k] + 1 : prev + prp;
        chk(ev_pre[i] == 0, "R3 data flag", ev_pre[i], 0);
        chk(ev_neg[i] == en_, "R3 data sign", ev_neg[i], en_);
        if (hop != 0) chk(ev_pos[i] == ep, "R7 hopped data position", ev_pos[i], ep);
        else          chk(ev_pos[i] == ep, "R3 data position", ev_pos[i], ep);
        if (acc[k] + 1 > prev + prp) chk(ev_cyc[i] == expc, "R6 stalled slot timing", ev_cyc[i], expc);
        else                         chk(ev_cyc[i] == expc, "R4 data slot timing", ev_cyc[i], expc);
      end
      chk(ev_pos[i] < (1 << nl), "R10 position below Np", ev_pos[i], (1 << nl) - 1);
      if (i < n_fire)
        chk(fire_cyc[i] == ev_cyc[i] + ev_pos[i] * sp, "R5 fire offset",
            fire_cyc[i], ev_cyc[i] + ev_pos[i] * sp);
      prev = ev_cyc[i];
    end
    if (n_ev > 0)
      chk(done_cyc == ev_cyc[n_ev-1] + prp - 1, "R8 done timing", done_cyc, ev_cyc[n_ev-1] + prp - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(slot_stb == 1'b0, "R4 reset slot strobe", int'(slot_stb), 0);
    chk(fire_stb == 1'b0, "R5 reset fire", int'(fire_stb), 0);
    chk(start_ack == 1'b0, "R1 reset ack", int'(start_ack), 0);
    chk(frame_done == 1'b0, "R8 reset done", int'(frame_done), 0);
    chk(bit_ready == 1'b0, "R9 reset ready", int'(bit_ready), 0);
    for (int i = 0; i < 16; i++) begin
      tbl_we = 1'b1; tbl_addr = 4'(i); tbl_wdata = 4'((t_neg(i) << 3) | t_hop(i));
      @(negedge clk);
    end
    tbl_we = 1'b0;
    repeat (3) @(negedge clk);
    run_frame(1, 6, 3, 5, 4, 0, 0, 0);
    run_frame(2, 8, 2, 4, 8, 1, 20, 0);
    run_frame(3, 9, 1, 16, 16, 0, 0, 0);
    run_frame(3, 9, 1, 2, 20, 1, 30, 1);
    run_frame(1, 2, 1, 0, 4, 0, 0, 0);
    run_frame(2, 7, 2, 3, 0, 0, 0, 0);
    run_frame(2, 13, 4, 16, 12, 1, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule